// File: doc/BRIEF.md
# Flash Command Interface with Erase and Program Suspend

This block decodes command bytes written by a host and sequences erase, program and block-protection operations for a modelled flash bank array. Each command byte arrives as a one-cycle write with a block number beside it. Erase and program take a configurable number of clock cycles, each counted by its own busy counter. An erase or a program can be paused with a suspend command and continued with a resume command. While an erase is paused, the host may change block protection or program a different block.

The block keeps an 8-bit status byte. Bit 7 means ready. Bit 6 means an erase is suspended. Bit 5 flags an erase or command-sequence fault. Bit 4 flags a program or command-sequence fault. Bit 2 means a program is suspended. Bit 1 means an operation was attempted on a protected block. Bits 3 and 0 read 0.

Fault bits 5 and 4 are sticky. Once a bad protection sequence sets them during an erase pause, a later erase failure can no longer be told apart from it. A read-mode output tells the surrounding logic whether reads return array data, status or identification data. A protection-state vector carries two bits per block: bit 0 means locked and bit 1 means locked down, so 00 is unlocked, 01 is locked and 11 is locked down.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the status byte is 0x80, the read mode is array (0) and every block is locked (01).
- R2: 0xFF selects array mode (0), 0x70 selects status mode (1) and 0x90 selects identification mode (2). The erase setup (0x20) and program setup (0x40) commands also select status mode.
- R3: Erase is 0x20 then 0xD0, and program is 0x40 then any byte, on an unlocked block. Either one clears ready for exactly ERASE_CYC or PROG_CYC cycles after the second byte. If op_fail is high when the count ends, an erase sets bit 5 and a program sets bit 4.
- R4: Erase confirmed on a locked block sets bits 5 and 1. Program on a locked block sets bits 4 and 1. In both cases ready stays 1.
- R5: 0xB0 during a running erase sets bit 6 and ready on the next cycle and freezes the count. 0xD0 resumes the count from the frozen value, and the erase completes after the remaining cycles.
- R6: 0xB0 during a running program sets bit 2 and ready. 0xD0 resumes and completes the program.
- R7: 0x60 then 0x01 locks the block, 0x60 then 0xD0 unlocks it, and 0x60 then 0x2F locks it down (11). Unlock has no effect on a locked-down block.
- R8: Protection sequences are accepted during an erase suspend and change the block state at once, even on the block being erased. That erase still completes after resume.
- R9: 0x60 while a program is suspended is refused: protection states stay unchanged and bits 5 and 4 are set. The following byte is decoded as a fresh command.
- R10: A second byte other than 0x01, 0xD0 or 0x2F after 0x60 sets bits 5 and 4. The same happens for a byte other than 0xD0 after 0x20.
- R11: Bits 5 and 4 stay set through suspend, resume and operation completion. Only 0x50 clears them, together with bit 1.
- R12: While an erase or program is counting, only 0xB0 and 0x70 are acted on. All other bytes leave mode, status and protection unchanged.
- R13: A program on another unlocked block may run during an erase suspend. When it ends, the status returns to 0xC0 with the erase still suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_blk | input | $clog2(NBLK) | Target block of the write |
| op_fail | input | 1 | Cell verify outcome sampled when an operation ends |
| status | output | 8 | Status byte |
| rd_mode | output | 2 | Read mode: 0 array, 1 status, 2 identification |
| lock_state | output | 2*NBLK | Per-block protection state, two bits each |

## Verification
The bench builds the block with NBLK=4, ERASE_CYC=20 and PROG_CYC=6. These short counts let it check the last busy cycle and the first ready cycle of every operation, including an erase split by a suspend into a known frozen remainder. Four blocks are enough to keep a locked, a locked-down and two unlocked blocks at once. That allows a protection change on the erase target and a nested program on a different block within one suspend.

// File: rtl/fci_pkg.sv
package fci_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_IDENT  = 2'd2
   } rd_mode_e;

   typedef enum logic [1:0] {
      PD_NONE  = 2'd0,
      PD_ERASE = 2'd1,
      PD_PROG  = 2'd2,
      PD_LOCK  = 2'd3
   } pend_e;

   typedef enum logic [1:0] {
      LK_NONE   = 2'd0,
      LK_SET    = 2'd1,
      LK_CLEAR  = 2'd2,
      LK_FREEZE = 2'd3
   } lk_op_e;

   localparam logic [7:0] C_ERASE_SU = 8'h20;
   localparam logic [7:0] C_PROG_SU  = 8'h40;
   localparam logic [7:0] C_CONFIRM  = 8'hD0;
   localparam logic [7:0] C_SUSPEND  = 8'hB0;
   localparam logic [7:0] C_PROT_SU  = 8'h60;
   localparam logic [7:0] C_PROT_SET = 8'h01;
   localparam logic [7:0] C_PROT_DN  = 8'h2F;
   localparam logic [7:0] C_CLR_SR   = 8'h50;
   localparam logic [7:0] C_RD_SR    = 8'h70;
   localparam logic [7:0] C_RD_ID    = 8'h90;
   localparam logic [7:0] C_RD_ARR   = 8'hFF;

endpackage

// File: rtl/fci_op_timer.sv
module fci_op_timer #(
   parameter int CNT_W = 16,
   parameter int LEN   = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic hold,
   output logic busy,
   output logic done
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   initial begin
      assert (LEN >= 2) else $error("operation length must be at least 2");
      assert (LEN < (2 ** CNT_W)) else $error("operation length exceeds counter");
   end

   assign busy = busy_q;
   assign done = busy_q & ~hold & (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end else if (busy_q && !hold) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) busy_q <= 1'b0;
      end
   end

   assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && hold && !start) |=> (busy_q && $stable(cnt_q)));

endmodule

// File: rtl/fci_lock_bank.sv
module fci_lock_bank
   import fci_pkg::*;
#(
   parameter int NBLK         = 8,
   parameter int BLK_W        = 3,
   parameter bit RESET_LOCKED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  lk_op_e            op,
   input  logic [BLK_W-1:0]  blk,
   output logic [2*NBLK-1:0] state
);

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      logic [1:0] st_q;
      logic [1:0] rst_v;
      logic       hit;

      if (RESET_LOCKED) begin : g_rst_locked
         assign rst_v = 2'b01;
      end else begin : g_rst_open
         assign rst_v = 2'b00;
      end

      assign hit = we && (blk == BLK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= rst_v;
         end else if (hit) begin
            unique case (op)
               LK_SET:    st_q <= {st_q[1], 1'b1};
               LK_CLEAR:  if (!st_q[1]) st_q <= 2'b00;
               LK_FREEZE: st_q <= 2'b11;
               default:   st_q <= st_q;
            endcase
         end
      end

      assign state[2*b +: 2] = st_q;

      assert_lockdown_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == 2'b11) |=> (st_q == 2'b11));
   end

endmodule

// File: rtl/fci_seq.sv
module fci_seq
   import fci_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_data,
   input  logic       blk_locked,
   input  logic       op_fail,
   input  logic       e_busy,
   input  logic       e_done,
   input  logic       p_busy,
   input  logic       p_done,
   output logic       e_start,
   output logic       p_start,
   output logic       e_hold,
   output logic       p_hold,
   output logic       lk_we,
   output lk_op_e     lk_op,
   output logic [7:0] status,
   output rd_mode_e   rd_mode
);

   pend_e    pend_q, pend_d;
   rd_mode_e mode_q, mode_d;
   logic     esusp_q, esusp_d;
   logic     psusp_q, psusp_d;
   logic     sr5_q, sr5_d;
   logic     sr4_q, sr4_d;
   logic     sr1_q, sr1_d;
   logic     e_run, p_run, running;

   assign e_run   = e_busy && !esusp_q;
   assign p_run   = p_busy && !psusp_q;
   assign running = e_run || p_run;

   always_comb begin
      pend_d  = pend_q;
      mode_d  = mode_q;
      esusp_d = esusp_q;
      psusp_d = psusp_q;
      sr5_d   = sr5_q;
      sr4_d   = sr4_q;
      sr1_d   = sr1_q;
      e_start = 1'b0;
      p_start = 1'b0;
      lk_we   = 1'b0;
      lk_op   = LK_NONE;

      if (e_done && op_fail) sr5_d = 1'b1;
      if (p_done && op_fail) sr4_d = 1'b1;

      if (cmd_valid) begin
         if (pend_q != PD_NONE) begin
            pend_d = PD_NONE;
            unique case (pend_q)
               PD_ERASE: begin
                  if (cmd_data != C_CONFIRM) begin
                     sr5_d = 1'b1;
                     sr4_d = 1'b1;
                  end else if (blk_locked) begin
                     sr5_d = 1'b1;
                     sr1_d = 1'b1;
                  end else begin
                     e_start = 1'b1;
                  end
               end
               PD_PROG: begin
                  if (blk_locked) begin
                     sr4_d = 1'b1;
                     sr1_d = 1'b1;
                  end else begin
                     p_start = 1'b1;
                  end
               end
               PD_LOCK: begin
                  lk_we = 1'b1;
                  unique case (cmd_data)
                     C_PROT_SET: lk_op = LK_SET;
                     C_CONFIRM:  lk_op = LK_CLEAR;
                     C_PROT_DN:  lk_op = LK_FREEZE;
                     default: begin
                        lk_we = 1'b0;
                        sr5_d = 1'b1;
                        sr4_d = 1'b1;
                     end
                  endcase
               end
               default: ;
            endcase
         end else if (running) begin
            if (cmd_data == C_SUSPEND) begin
               if (p_run) begin
                  if (!p_done) psusp_d = 1'b1;
               end else if (!e_done) begin
                  esusp_d = 1'b1;
               end
            end else if (cmd_data == C_RD_SR) begin
               mode_d = RM_STATUS;
            end
         end else begin
            unique case (cmd_data)
               C_ERASE_SU: if (!e_busy && !psusp_q) begin
                  pend_d = PD_ERASE;
                  mode_d = RM_STATUS;
               end
               C_PROG_SU: if (!p_busy) begin
                  pend_d = PD_PROG;
                  mode_d = RM_STATUS;
               end
               C_PROT_SU: begin
                  if (psusp_q) begin
                     sr5_d = 1'b1;
                     sr4_d = 1'b1;
                  end else begin
                     pend_d = PD_LOCK;
                  end
               end
               C_CONFIRM: begin
                  if (psusp_q)      psusp_d = 1'b0;
                  else if (esusp_q) esusp_d = 1'b0;
               end
               C_CLR_SR: begin
                  sr5_d = 1'b0;
                  sr4_d = 1'b0;
                  sr1_d = 1'b0;
               end
               C_RD_SR:  mode_d = RM_STATUS;
               C_RD_ID:  mode_d = RM_IDENT;
               C_RD_ARR: mode_d = RM_ARRAY;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= PD_NONE;
         mode_q  <= RM_ARRAY;
         esusp_q <= 1'b0;
         psusp_q <= 1'b0;
         sr5_q   <= 1'b0;
         sr4_q   <= 1'b0;
         sr1_q   <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         mode_q  <= mode_d;
         esusp_q <= esusp_d;
         psusp_q <= psusp_d;
         sr5_q   <= sr5_d;
         sr4_q   <= sr4_d;
         sr1_q   <= sr1_d;
      end
   end

   assign e_hold  = esusp_q;
   assign p_hold  = psusp_q;
   assign rd_mode = mode_q;
   assign status  = {~running, esusp_q, sr5_q, sr4_q, 1'b0, psusp_q, sr1_q, 1'b0};

   assert_sr4_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && !(cmd_valid && cmd_data == C_CLR_SR)) |=> status[4]);

   assert_sr5_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status[5] && !(cmd_valid && cmd_data == C_CLR_SR)) |=> status[5]);

   assert_no_prot_in_psusp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      psusp_q |-> !lk_we);

   assert_one_runner_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({e_run, p_run}));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
   import fci_pkg::*;
#(
   parameter int NBLK         = 8,
   parameter int CNT_W        = 16,
   parameter int ERASE_CYC    = 64,
   parameter int PROG_CYC     = 16,
   parameter bit RESET_LOCKED = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [7:0]              cmd_data,
   input  logic [$clog2(NBLK)-1:0] cmd_blk,
   input  logic                    op_fail,
   output logic [7:0]              status,
   output logic [1:0]              rd_mode,
   output logic [2*NBLK-1:0]       lock_state
);

   localparam int BLK_W = $clog2(NBLK);

   initial begin
      assert (NBLK >= 2) else $error("at least two blocks required");
      assert (CNT_W >= 2) else $error("counter too narrow");
   end

   logic     e_start, p_start, e_hold, p_hold;
   logic     e_busy, p_busy, e_done, p_done;
   logic     lk_we, blk_locked;
   lk_op_e   lk_op;
   rd_mode_e mode_w;

   assign blk_locked = lock_state[{cmd_blk, 1'b0}];
   assign rd_mode    = mode_w;

   fci_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_data   (cmd_data),
      .blk_locked (blk_locked),
      .op_fail    (op_fail),
      .e_busy     (e_busy),
      .e_done     (e_done),
      .p_busy     (p_busy),
      .p_done     (p_done),
      .e_start    (e_start),
      .p_start    (p_start),
      .e_hold     (e_hold),
      .p_hold     (p_hold),
      .lk_we      (lk_we),
      .lk_op      (lk_op),
      .status     (status),
      .rd_mode    (mode_w)
   );

   fci_op_timer #(.CNT_W(CNT_W), .LEN(ERASE_CYC)) u_erase_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (e_start),
      .hold  (e_hold),
      .busy  (e_busy),
      .done  (e_done)
   );

   fci_op_timer #(.CNT_W(CNT_W), .LEN(PROG_CYC)) u_prog_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (p_start),
      .hold  (p_hold),
      .busy  (p_busy),
      .done  (p_done)
   );

   fci_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W), .RESET_LOCKED(RESET_LOCKED)) u_locks (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lk_we),
      .op    (lk_op),
      .blk   (cmd_blk),
      .state (lock_state)
   );

endmodule

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NB = 4;
   localparam int EC = 20;
   localparam int PC = 6;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cmd_valid;
   logic [7:0]      cmd_data;
   logic [1:0]      cmd_blk;
   logic            op_fail;
   logic [7:0]      status;
   logic [1:0]      rd_mode;
   logic [2*NB-1:0] lock_state;

   always #2.5 clk = ~clk;

   flash_cmd_if #(.NBLK(NB), .CNT_W(8), .ERASE_CYC(EC), .PROG_CYC(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_blk(cmd_blk), .op_fail(op_fail), .status(status), .rd_mode(rd_mode),
      .lock_state(lock_state)
   );

   typedef struct {
      logic [7:0]      st;
      logic [1:0]      md;
      logic [2*NB-1:0] lk;
      string           tag;
   } exp_t;

   exp_t q[$];
   event chk_ev;
   int   n_chk = 0;
   int   n_err = 0;
   bit   finished = 0;
   logic [1:0]      md_exp;
   logic [2*NB-1:0] lk_exp;

   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (status !== e.st || rd_mode !== e.md || lock_state !== e.lk) begin
               n_err++;
               $display("FAIL %s: got status=%h mode=%0d lock=%b, expected status=%h mode=%0d lock=%b",
                        e.tag, status, rd_mode, lock_state, e.st, e.md, e.lk);
            end
         end
      end
   end

   task automatic expect_st(input logic [7:0] st, input string tag);
      exp_t e;
      e.st = st; e.md = md_exp; e.lk = lk_exp; e.tag = tag;
      q.push_back(e);
      ->chk_ev;
   endtask

   task automatic send(input logic [7:0] d, input logic [1:0] b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_data = d; cmd_blk = b;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: got running, expected completion");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; cmd_blk = '0; op_fail = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      md_exp = 2'd0; lk_exp = 8'b01010101;
      expect_st(8'h80, "R1 reset state");

      send(8'h90, 0); md_exp = 2'd2; expect_st(8'h80, "R2 ident mode");
      send(8'h70, 0); md_exp = 2'd1; expect_st(8'h80, "R2 status mode");
      send(8'hFF, 0); md_exp = 2'd0; expect_st(8'h80, "R2 array mode");

      send(8'h60, 1); send(8'hD0, 1); lk_exp = 8'b01010001; expect_st(8'h80, "R7 unlock blk1");
      send(8'h60, 2); send(8'hD0, 2); lk_exp = 8'b01000001; expect_st(8'h80, "R7 unlock blk2");
      send(8'h60, 3); send(8'h2F, 3); lk_exp = 8'b11000001; expect_st(8'h80, "R7 lock-down blk3");
      send(8'h60, 3); send(8'hD0, 3); expect_st(8'h80, "R7 unlock ignored on locked-down");

      send(8'h60, 0); send(8'h33, 0); expect_st(8'hB0, "R10 bad protection byte");
      send(8'h50, 0); expect_st(8'h80, "R11 clear status");
      send(8'h20, 1); send(8'h77, 1); md_exp = 2'd1; expect_st(8'hB0, "R10 bad erase confirm");
      send(8'h50, 0); expect_st(8'h80, "R11 clear status again");

      send(8'h20, 0); send(8'hD0, 0); expect_st(8'hA2, "R4 erase on locked block");
      send(8'h50, 0);
      send(8'h40, 0); send(8'h55, 0); expect_st(8'h92, "R4 program on locked block");
      send(8'h50, 0); expect_st(8'h80, "R11 clear after R4");

      // plain erase with ignored bytes while counting
      send(8'h20, 1); send(8'hD0, 1); expect_st(8'h00, "R3 erase started");
      send(8'hFF, 0); expect_st(8'h00, "R12 mode change ignored while busy");
      send(8'h60, 2); send(8'h01, 2); expect_st(8'h00, "R12 protection ignored while busy");
      idle(EC - 1 - 6); expect_st(8'h00, "R3 last erase busy cycle");
      idle(1); expect_st(8'h80, "R3 erase complete");

      op_fail = 1'b1;
      send(8'h40, 2); send(8'h5A, 2); expect_st(8'h00, "R3 program started");
      idle(PC - 1); expect_st(8'h00, "R3 last program busy cycle");
      idle(1); expect_st(8'h90, "R3 program failure flag");
      op_fail = 1'b0;
      send(8'h50, 0); expect_st(8'h80, "R11 clear after program failure");

      // erase suspend, protection changes, sticky fault across resume
      send(8'h20, 1); send(8'hD0, 1);
      idle(3);
      send(8'hB0, 0); expect_st(8'hC0, "R5 erase suspended");
      idle(4); expect_st(8'hC0, "R5 count frozen while suspended");
      send(8'h60, 1); send(8'h01, 1); lk_exp = 8'b11000101; expect_st(8'hC0, "R8 lock erase target in suspend");
      send(8'h60, 1); send(8'h44, 1); expect_st(8'hF0, "R11 protection fault in suspend");
      send(8'hD0, 0); expect_st(8'h30, "R5 erase resumed");
      op_fail = 1'b1;
      idle(EC - 5 - 1); expect_st(8'h30, "R5 last resumed busy cycle");
      idle(1); expect_st(8'hB0, "R8 erase completes; R11 failure hidden");
      op_fail = 1'b0;
      send(8'h50, 0); expect_st(8'h80, "R11 clear after hidden failure");
      send(8'h60, 1); send(8'hD0, 1); lk_exp = 8'b11000001; expect_st(8'h80, "R7 unlock blk1 again");

      // nested program during erase suspend
      send(8'h20, 1); send(8'hD0, 1);
      idle(2);
      send(8'hB0, 0); expect_st(8'hC0, "R13 erase suspended");
      send(8'h40, 2); send(8'h11, 2); expect_st(8'h40, "R13 nested program running");
      idle(PC - 1); expect_st(8'h40, "R13 nested program last busy cycle");
      idle(1); expect_st(8'hC0, "R13 back to erase suspended");
      send(8'hD0, 0); expect_st(8'h00, "R5 resume after nested program");
      idle(EC - 4 - 1); expect_st(8'h00, "R5 remaining erase busy");
      idle(1); expect_st(8'h80, "R5 erase complete after nesting");

      // program suspend and refused protection
      send(8'h40, 2); send(8'h22, 2);
      send(8'hB0, 0); expect_st(8'h84, "R6 program suspended");
      send(8'h60, 2); expect_st(8'hB4, "R9 protection setup refused");
      send(8'h01, 2); expect_st(8'hB4, "R9 next byte decoded fresh, no lock");
      send(8'h50, 0); expect_st(8'h84, "R11 clear in program suspend");
      send(8'hD0, 0); expect_st(8'h00, "R6 program resumed");
      idle(PC - 2 - 1); expect_st(8'h00, "R6 last resumed program cycle");
      idle(1); expect_st(8'h80, "R6 program complete");

      idle(2);
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule